// File: doc/BRIEF.md
# Reorder Buffer with Deferred Exceptions

This block keeps the program order of an out-of-order core. Every dispatched instruction takes the next slot of a circular buffer, and the slot index serves as its result tag. Execution units return results on one result bus, addressed by that tag. A result may carry a fault flag. Results stay in their slots, uncommitted. They reach the architectural register file only when their slot retires from the head, one slot per cycle, strictly in program order.

A rename map holds, for each architectural register, the tag of its youngest pending writer. A source lookup returns one of three things: the architectural value, the finished value still held in a slot, or the tag to wait on. A fault flag has no effect until its slot reaches the head. At that point the faulting instruction is dropped, every slot is squashed, the rename map is cleared and fetch is redirected to the handler address on an input.

An interrupt request is taken at a retirement. The retiring instruction commits first, and everything younger is squashed.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `count_o` is 0, `disp_ready_o` is 1, nothing commits or flushes, and every register reads as value 0 with `src_pending_o` low.
- R2: Slots are allocated in order and tags count up modulo DEPTH, with `disp_tag_o` giving the slot the next dispatch takes. `count_o` follows allocations and retirements. When DEPTH slots are in use, `disp_ready_o` is 0 and a dispatch has no effect on the count.
- R3: The head slot retires only after its result has arrived. A finished younger slot never commits ahead of an unfinished older one.
- R4: A lookup of a register whose youngest pending writer has finished returns that writer's value with `src_ready_o` high. If the writer has not finished, `src_ready_o` is low and `src_data_o` is 0.
- R5: The lookup tag (`src_tag_o`) is always that of the youngest pending writer of the register. When an older writer of the same register retires, the register stays pending on the younger one.
- R6: A retiring slot without a fault writes its value to its destination register. This shows on `commit_valid_o`, `commit_reg_o` and `commit_data_o`. A register with no pending writer reads its architectural value, and `src_tag_o` is then 0.
- R7: A fault flag has no effect while its slot is not at the head. When a flagged slot reaches the head, it does not commit. `flush_o` rises with `redirect_pc_o` equal to `handler_pc_i` and `flush_cause_o` = 0, and the buffer is empty in the next cycle.
- R8: With `irq_i` high while a fault-free finished slot is at the head, that slot commits and in the same cycle `flush_o` rises with `flush_cause_o` = 1. Younger slots, including those that carry fault flags, are discarded and never commit or flush.
- R9: After any flush, every register reads its architectural value with `src_pending_o` low.
- R10: A result written to the head slot makes it retire in the following cycle, never in the cycle the result arrives.
- R11: At most one slot is allocated and at most one retires per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dst_i | input | RW | Destination register of the dispatched instruction |
| disp_ready_o | output | 1 | Dispatch is accepted this cycle |
| disp_tag_o | output | TW | Tag the next accepted dispatch receives |
| res_valid_i | input | 1 | Result bus valid |
| res_tag_i | input | TW | Slot addressed by the result |
| res_data_i | input | XLEN | Result value |
| res_exc_i | input | 1 | Result carries a fault |
| irq_i | input | 1 | Interrupt request |
| handler_pc_i | input | PCW | Fetch target on a flush |
| src_reg_i | input | RW | Register looked up |
| src_ready_o | output | 1 | Looked-up value is available |
| src_pending_o | output | 1 | Register has an uncommitted writer |
| src_tag_o | output | TW | Tag of the youngest pending writer |
| src_data_o | output | XLEN | Looked-up value |
| commit_valid_o | output | 1 | A slot writes the register file this cycle |
| commit_reg_o | output | RW | Register written by the commit |
| commit_data_o | output | XLEN | Value written by the commit |
| flush_o | output | 1 | Squash and redirect this cycle |
| flush_cause_o | output | 1 | 0 fault, 1 interrupt |
| redirect_pc_o | output | PCW | Redirect target, 0 when no flush |
| count_o | output | TW+1 | Slots in use |

## Verification
The assertions assume that a result is sent only to a slot that is allocated and not yet finished, and never in a cycle that flushes. They also assume the core dispatches only while `disp_ready_o` is high, although the block itself blocks any other dispatch. The bench keeps a model of the slots, from which it draws each result tag among the live unfinished slots, and it holds results back whenever the model predicts a flush. Random dispatch, fault and interrupt rates are set so that the buffer regularly fills and empties.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic {
    CAUSE_EXC = 1'b0,
    CAUSE_IRQ = 1'b1
  } cause_e;
endpackage

// File: rtl/rob_ring.sv
`timescale 1ns/1ps
module rob_ring #(
  parameter int DEPTH = 16,
  parameter int RW    = 4,
  parameter int XLEN  = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_i,
  input  logic [RW-1:0]   alloc_dst_i,
  input  logic            res_valid_i,
  input  logic [TW-1:0]   res_tag_i,
  input  logic [XLEN-1:0] res_data_i,
  input  logic            res_exc_i,
  input  logic            retire_i,
  input  logic            flush_i,
  input  logic [TW-1:0]   rd_tag_i,
  output logic [TW-1:0]   head_o,
  output logic [TW-1:0]   tail_o,
  output logic [CW-1:0]   cnt_o,
  output logic            head_valid_o,
  output logic            head_done_o,
  output logic            head_exc_o,
  output logic [RW-1:0]   head_dst_o,
  output logic [XLEN-1:0] head_data_o,
  output logic            rd_done_o,
  output logic [XLEN-1:0] rd_data_o
);
  logic [DEPTH-1:0] vld_q, done_q, exc_q;
  logic [RW-1:0]    dst_q  [DEPTH];
  logic [XLEN-1:0]  data_q [DEPTH];
  logic [TW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic             res_ok;

  // a result to the slot retiring this cycle is dropped
  assign res_ok = res_valid_i && vld_q[res_tag_i] && !(retire_i && res_tag_i == head_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      done_q <= '0;
      exc_q  <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        dst_q[e]  <= '0;
        data_q[e] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else begin
      if (retire_i) vld_q[head_q] <= 1'b0;
      if (res_ok) begin
        done_q[res_tag_i] <= 1'b1;
        exc_q[res_tag_i]  <= res_exc_i;
        data_q[res_tag_i] <= res_data_i;
      end
      if (alloc_i) begin
        vld_q[tail_q]  <= 1'b1;
        done_q[tail_q] <= 1'b0;
        exc_q[tail_q]  <= 1'b0;
        dst_q[tail_q]  <= alloc_dst_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (retire_i) head_q <= head_q + TW'(1);
      if (alloc_i)  tail_q <= tail_q + TW'(1);
      cnt_q <= cnt_q + CW'(alloc_i) - CW'(retire_i);
    end
  end

  assign head_o       = head_q;
  assign tail_o       = tail_q;
  assign cnt_o        = cnt_q;
  assign head_valid_o = vld_q[head_q];
  assign head_done_o  = done_q[head_q];
  assign head_exc_o   = exc_q[head_q];
  assign head_dst_o   = dst_q[head_q];
  assign head_data_o  = data_q[head_q];
  assign rd_done_o    = done_q[rd_tag_i];
  assign rd_data_o    = data_q[rd_tag_i];

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> cnt_q < CW'(DEPTH));
  p_ptr_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_q - head_q) == cnt_q[TW-1:0]);
  p_cnt_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(flush_i) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CW'(1)
                         || cnt_q + CW'(1) == $past(cnt_q)));
  p_res_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !flush_i) |-> (vld_q[res_tag_i] && !done_q[res_tag_i]));
endmodule

// File: rtl/rob_rename.sv
`timescale 1ns/1ps
module rob_rename #(
  parameter int NREG  = 16,
  parameter int DEPTH = 16,
  localparam int RW   = $clog2(NREG),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [RW-1:0] alloc_reg_i,
  input  logic [TW-1:0] alloc_tag_i,
  input  logic          commit_i,
  input  logic [RW-1:0] commit_reg_i,
  input  logic [TW-1:0] commit_tag_i,
  input  logic          flush_i,
  input  logic [RW-1:0] rd_reg_i,
  output logic          rd_pend_o,
  output logic [TW-1:0] rd_tag_o
);
  logic [NREG-1:0] pend_q;
  logic [TW-1:0]   tag_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int r = 0; r < NREG; r++) tag_q[r] <= '0;
    end else if (flush_i) begin
      pend_q <= '0;
    end else begin
      // commit clears only if no younger writer took the register
      if (commit_i && pend_q[commit_reg_i] && tag_q[commit_reg_i] == commit_tag_i)
        pend_q[commit_reg_i] <= 1'b0;
      if (alloc_i) begin
        pend_q[alloc_reg_i] <= 1'b1;
        tag_q[alloc_reg_i]  <= alloc_tag_i;
      end
    end
  end

  assign rd_pend_o = pend_q[rd_reg_i];
  assign rd_tag_o  = tag_q[rd_reg_i];

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> pend_q == '0);
  p_latest_tag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !flush_i) |=> (pend_q[$past(alloc_reg_i)] && tag_q[$past(alloc_reg_i)] == $past(alloc_tag_i)));
endmodule

// File: rtl/rob_arf.sv
`timescale 1ns/1ps
module rob_arf #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) rf_q[r] <= '0;
    end else if (we_i) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = rf_q[raddr_i];

  p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core import rob_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int NREG  = 16,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG),
  localparam int CW   = TW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            disp_valid_i,
  input  logic [RW-1:0]   disp_dst_i,
  output logic            disp_ready_o,
  output logic [TW-1:0]   disp_tag_o,
  input  logic            res_valid_i,
  input  logic [TW-1:0]   res_tag_i,
  input  logic [XLEN-1:0] res_data_i,
  input  logic            res_exc_i,
  input  logic            irq_i,
  input  logic [PCW-1:0]  handler_pc_i,
  input  logic [RW-1:0]   src_reg_i,
  output logic            src_ready_o,
  output logic            src_pending_o,
  output logic [TW-1:0]   src_tag_o,
  output logic [XLEN-1:0] src_data_o,
  output logic            commit_valid_o,
  output logic [RW-1:0]   commit_reg_o,
  output logic [XLEN-1:0] commit_data_o,
  output logic            flush_o,
  output logic            flush_cause_o,
  output logic [PCW-1:0]  redirect_pc_o,
  output logic [CW-1:0]   count_o
);
  logic [TW-1:0]   head, tail;
  logic [CW-1:0]   cnt;
  logic            head_valid, head_done, head_exc;
  logic [RW-1:0]   head_dst;
  logic [XLEN-1:0] head_data;
  logic            rd_done;
  logic [XLEN-1:0] rd_data;
  logic            map_pend;
  logic [TW-1:0]   map_tag;
  logic [XLEN-1:0] arf_data;
  logic            retire, exc_take, irq_take, flush, commit, alloc;
  cause_e          cause;

  assign retire   = head_valid && head_done;
  assign exc_take = retire && head_exc;
  assign irq_take = retire && !head_exc && irq_i;
  assign flush    = exc_take || irq_take;
  assign commit   = retire && !head_exc;
  assign disp_ready_o = (cnt < CW'(DEPTH)) && !flush;
  assign alloc    = disp_valid_i && disp_ready_o;
  assign cause    = irq_take ? CAUSE_IRQ : CAUSE_EXC;

  rob_ring #(.DEPTH(DEPTH), .RW(RW), .XLEN(XLEN)) u_ring (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .alloc_dst_i(disp_dst_i),
    .res_valid_i, .res_tag_i, .res_data_i, .res_exc_i,
    .retire_i(retire), .flush_i(flush), .rd_tag_i(map_tag),
    .head_o(head), .tail_o(tail), .cnt_o(cnt),
    .head_valid_o(head_valid), .head_done_o(head_done), .head_exc_o(head_exc),
    .head_dst_o(head_dst), .head_data_o(head_data),
    .rd_done_o(rd_done), .rd_data_o(rd_data)
  );

  rob_rename #(.NREG(NREG), .DEPTH(DEPTH)) u_map (
    .clk_i, .rst_ni,
    .alloc_i(alloc), .alloc_reg_i(disp_dst_i), .alloc_tag_i(tail),
    .commit_i(commit), .commit_reg_i(head_dst), .commit_tag_i(head),
    .flush_i(flush), .rd_reg_i(src_reg_i),
    .rd_pend_o(map_pend), .rd_tag_o(map_tag)
  );

  rob_arf #(.NREG(NREG), .XLEN(XLEN)) u_arf (
    .clk_i, .rst_ni,
    .we_i(commit), .waddr_i(head_dst), .wdata_i(head_data),
    .raddr_i(src_reg_i), .rdata_o(arf_data)
  );

  assign disp_tag_o     = tail;
  assign count_o        = cnt;
  assign src_pending_o  = map_pend;
  assign src_tag_o      = map_pend ? map_tag : '0;
  assign src_ready_o    = !map_pend || rd_done;
  assign src_data_o     = !map_pend ? arf_data : (rd_done ? rd_data : '0);
  assign commit_valid_o = commit;
  assign commit_reg_o   = commit ? head_dst : '0;
  assign commit_data_o  = commit ? head_data : '0;
  assign flush_o        = flush;
  assign flush_cause_o  = cause;
  assign redirect_pc_o  = flush ? handler_pc_i : '0;

  p_head_advances_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_o && !flush_o) |=> head == $past(head) + TW'(1));
  p_flush_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (count_o == '0 && !flush_o));
endmodule

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;
  localparam int DEPTH = 16;
  localparam int NREG  = 16;
  localparam int XLEN  = 32;
  localparam int PCW   = 32;
  localparam logic [31:0] HANDLER = 32'h0000_8100;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        disp_valid_i = 1'b0;
  logic [3:0]  disp_dst_i = '0;
  logic        disp_ready_o;
  logic [3:0]  disp_tag_o;
  logic        res_valid_i = 1'b0;
  logic [3:0]  res_tag_i = '0;
  logic [31:0] res_data_i = '0;
  logic        res_exc_i = 1'b0;
  logic        irq_i = 1'b0;
  logic [31:0] handler_pc_i = HANDLER;
  logic [3:0]  src_reg_i = '0;
  logic        src_ready_o, src_pending_o;
  logic [3:0]  src_tag_o;
  logic [31:0] src_data_o;
  logic        commit_valid_o;
  logic [3:0]  commit_reg_o;
  logic [31:0] commit_data_o;
  logic        flush_o, flush_cause_o;
  logic [31:0] redirect_pc_o;
  logic [4:0]  count_o;

  rob_core #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .PCW(PCW)) u0 (
    .clk_i(clk), .rst_ni,
    .disp_valid_i, .disp_dst_i, .disp_ready_o, .disp_tag_o,
    .res_valid_i, .res_tag_i, .res_data_i, .res_exc_i,
    .irq_i, .handler_pc_i,
    .src_reg_i, .src_ready_o, .src_pending_o, .src_tag_o, .src_data_o,
    .commit_valid_o, .commit_reg_o, .commit_data_o,
    .flush_o, .flush_cause_o, .redirect_pc_o, .count_o
  );

  always #10 clk = ~clk;  // 50 MHz

  // bench model of the buffer, rename map and register file
  bit          m_v [DEPTH];
  bit          m_done [DEPTH];
  bit          m_exc [DEPTH];
  int          m_dst [DEPTH];
  logic [31:0] m_data [DEPTH];
  bit          m_pv [NREG];
  int          m_pt [NREG];
  logic [31:0] m_arf [NREG];
  int          m_head, m_tail, m_cnt;
  int          n_chk = 0, n_bad = 0;
  bit          fin = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit pred_flush(bit irq);
    bit take = m_v[m_head] && m_done[m_head];
    return take && (m_exc[m_head] || irq);
  endfunction

  task automatic cyc(bit dv, int dd, bit rv, int rt, logic [31:0] rd, bit re, bit irq, int sr);
    bit take, ex, it, fl, cv, rdy, rok;
    disp_valid_i = dv; disp_dst_i = 4'(dd);
    res_valid_i = rv; res_tag_i = 4'(rt); res_data_i = rd; res_exc_i = re;
    irq_i = irq; src_reg_i = 4'(sr);
    #1;
    take = m_v[m_head] && m_done[m_head];
    ex   = take && m_exc[m_head];
    it   = take && !m_exc[m_head] && irq;
    fl   = ex || it;
    cv   = take && !m_exc[m_head];
    rdy  = (m_cnt < DEPTH) && !fl;
    chk("R2 count", 32'(count_o), 32'(m_cnt));
    chk("R2 ready", 32'(disp_ready_o), 32'(rdy));
    if (rdy) chk("R2 tag", 32'(disp_tag_o), 32'(m_tail));
    chk("R3 commit", 32'(commit_valid_o), 32'(cv));
    if (cv) begin
      chk("R6 commit reg", 32'(commit_reg_o), 32'(m_dst[m_head]));
      chk("R6 commit data", commit_data_o, m_data[m_head]);
    end
    chk("R7 flush", 32'(flush_o), 32'(fl));
    if (fl) begin
      chk("R8 cause", 32'(flush_cause_o), 32'(it));
      chk("R7 redirect", redirect_pc_o, HANDLER);
    end
    chk("R5 pending", 32'(src_pending_o), 32'(m_pv[sr]));
    if (m_pv[sr]) begin
      chk("R5 tag", 32'(src_tag_o), 32'(m_pt[sr]));
      chk("R4 ready", 32'(src_ready_o), 32'(m_done[m_pt[sr]]));
      chk("R4 data", src_data_o, m_done[m_pt[sr]] ? m_data[m_pt[sr]] : 32'h0);
    end else begin
      chk("R6 arch ready", 32'(src_ready_o), 32'd1);
      chk("R6 arch data", src_data_o, m_arf[sr]);
    end
    @(posedge clk);
    rok = rv && m_v[rt] && !(take && rt == m_head) && !fl;
    if (take) begin
      if (cv) begin
        m_arf[m_dst[m_head]] = m_data[m_head];
        if (m_pv[m_dst[m_head]] && m_pt[m_dst[m_head]] == m_head) m_pv[m_dst[m_head]] = 1'b0;
      end
      m_v[m_head] = 1'b0;
      m_head = (m_head + 1) % DEPTH;
      m_cnt--;
    end
    if (rok) begin
      m_done[rt] = 1'b1; m_exc[rt] = re; m_data[rt] = rd;
    end
    if (dv && rdy) begin
      m_v[m_tail] = 1'b1; m_done[m_tail] = 1'b0; m_exc[m_tail] = 1'b0; m_dst[m_tail] = dd;
      m_pv[dd] = 1'b1; m_pt[dd] = m_tail;
      m_tail = (m_tail + 1) % DEPTH;
      m_cnt++;
    end
    if (fl) begin
      for (int e = 0; e < DEPTH; e++) m_v[e] = 1'b0;
      for (int r = 0; r < NREG; r++) m_pv[r] = 1'b0;
      m_head = 0; m_tail = 0; m_cnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(int sr);
    cyc(0, 0, 0, 0, 0, 0, 0, sr);
  endtask

  task automatic peek(int sr);
    src_reg_i = 4'(sr);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int e = 0; e < DEPTH; e++) begin
      m_v[e] = 0; m_done[e] = 0; m_exc[e] = 0; m_dst[e] = 0; m_data[e] = '0;
    end
    for (int r = 0; r < NREG; r++) begin
      m_pv[r] = 0; m_pt[r] = 0; m_arf[r] = '0;
    end
    m_head = 0; m_tail = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(5);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 ready", 32'(disp_ready_o), 1);
    chk("R1 commit", 32'(commit_valid_o), 0);
    chk("R1 flush", 32'(flush_o), 0);
    chk("R1 pending", 32'(src_pending_o), 0);
    chk("R1 data", src_data_o, 0);

    // R2 fill to full; slot 15 writes reg 4 again
    for (int i = 0; i < DEPTH; i++) cyc(1, (i == 15) ? 4 : i, 0, 0, 0, 0, 0, 0);
    cyc(1, 9, 0, 0, 0, 0, 0, 0);
    chk("R2 full count", 32'(count_o), 16);
    chk("R2 full ready", 32'(disp_ready_o), 0);

    // R5 youngest writer wins
    cyc(0, 0, 1, 4, 32'h44, 0, 0, 0);
    peek(4);
    chk("R5 youngest tag", 32'(src_tag_o), 15);
    chk("R5 not ready", 32'(src_ready_o), 0);

    // R4 bypass of finished younger slot; R3 no early commit
    cyc(0, 0, 1, 3, 32'h33, 0, 0, 0);
    peek(3);
    chk("R4 bypass", src_data_o, 32'h33);
    chk("R3 no early commit", 32'(commit_valid_o), 0);

    // R10 head result retires next cycle
    cyc(0, 0, 1, 0, 32'h10, 0, 0, 0);
    chk("R10 commit next cycle", 32'(commit_valid_o), 1);
    chk("R10 commit data", commit_data_o, 32'h10);
    cyc(0, 0, 1, 1, 32'h11, 0, 0, 0);
    cyc(0, 0, 1, 2, 32'h22, 0, 0, 0);
    idle(0); idle(0); idle(0);
    peek(4);
    chk("R5 older commit keeps pending", 32'(src_pending_o), 1);

    // R7 fault on younger slot is deferred
    cyc(0, 0, 1, 6, 32'h66, 1, 0, 0);
    chk("R7 deferred", 32'(flush_o), 0);
    cyc(0, 0, 1, 5, 32'h55, 0, 0, 0);
    idle(0);
    chk("R7 flush at head", 32'(flush_o), 1);
    chk("R7 no commit", 32'(commit_valid_o), 0);
    chk("R7 redirect", redirect_pc_o, HANDLER);
    idle(0);
    chk("R7 empty", 32'(count_o), 0);
    peek(7);
    chk("R9 cleared", 32'(src_pending_o), 0);
    chk("R9 arch value", src_data_o, 0);
    peek(5);
    chk("R6 committed value", src_data_o, 32'h55);

    // R8 interrupt at retirement discards faulting younger slot
    cyc(1, 7, 0, 0, 0, 0, 0, 0);
    cyc(1, 8, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 32'h80, 1, 0, 0);
    cyc(0, 0, 1, 0, 32'h70, 0, 0, 0);
    chk("R8 commit", 32'(commit_valid_o), 1);
    peek(8);
    cyc(0, 0, 0, 0, 0, 0, 1, 8);
    chk("R8 no further flush", 32'(flush_o), 0);
    peek(8);
    chk("R8 younger dropped", src_data_o, 0);
    peek(7);
    chk("R8 head committed", src_data_o, 32'h70);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit irq, dv, rv, re, fl;
      int rt;
      irq = ($urandom % 100) < 3;
      fl  = pred_flush(irq);
      rt  = $urandom % DEPTH;
      rv  = !fl && m_v[rt] && !m_done[rt] && (($urandom % 10) < 7);
      re  = ($urandom % 100) < 5;
      dv  = ($urandom % 10) < 6;
      cyc(dv, $urandom % NREG, rv, rt, $urandom, re, irq, $urandom % NREG);
    end

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule